// File: doc/BRIEF.md
# Headset Jack Detection Controller

This block is the digital sequencer behind a headset jack detector that serves both three-contact and four-contact plugs. Analog comparators outside the block watch the jack's sense pin and microphone pin. They hand in four synchronous flags: a wake flag, a plug flag, a removal flag and a button flag. A host enable and a one-millisecond tick complete the inputs. From these the block decides whether a plug is really present. It tells a film of moisture apart from a real plug. It also reports presses of the headset key and commands the microphone bias switch.

Every timed decision is counted in millisecond ticks by one shared debounce counter. Each timed path has its own length. Reaching the plugged state takes a qualification time with the plug flag held, nominally 80 ms and never more than 100 ms. A key press and a key release each need 30 ms of a steady button flag. On unplug, the plug-detect output stays low for a 40 ms hold. The key output and the bias switch drop at once. The current state is visible as a 3-bit code.

Top module: `jack_detect_ctrl`

## Requirements
- R1: During and after reset the state code is 0 (idle), plugDetN is high, keyPress and biasClose are low, and srcSelect is low (pull-up chosen; 1 means current source).
- R2: In idle, a high wakeFlag moves the block to sensing (code 1) at the next clock edge, and srcSelect goes high there.
- R3: In sensing, the block enters plugged (code 3) on the clock edge that samples the PLUG_MS-th tick seen while plugFlag stays continuously high. plugDetN goes low from that edge.
- R4: In sensing, a low plugFlag with no removal moves to moisture (code 2). In moisture, a high plugFlag returns to sensing with the count restarted from zero.
- R5: A high removeFlag in sensing or in moisture returns the block to idle (code 0) at the next edge. Removal takes priority over the other flags.
- R6: In plugged, a high hostEn moves to active (code 4) and closes the bias switch. In active or pressed, a low hostEn returns to plugged with no removal.
- R7: In active, buttonFlag held high for BTN_MS consecutive ticks enters pressed (code 5), and keyPress goes high. A shorter run has no effect and restarts the count.
- R8: In pressed, buttonFlag held low for BTN_MS consecutive ticks returns to active. A shorter low run restarts the count.
- R9: A high removeFlag in plugged, active or pressed enters release-hold (code 6) at the next edge. keyPress and biasClose go low at once while plugDetN stays low. The REL_MS-th tick in release-hold returns to idle.
- R10: plugDetN is low only in codes 3 to 6, biasClose is high only in codes 4 and 5, keyPress is high only in code 5, and srcSelect is high in every code but 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wakeFlag | input | 1 | Sense pin below the wake level |
| plugFlag | input | 1 | Sense pin below the plug level |
| removeFlag | input | 1 | Sense pin above the removal level |
| buttonFlag | input | 1 | Mic pin below the key trip level |
| hostEn | input | 1 | Host request to close the bias path |
| msTick | input | 1 | One-cycle pulse every millisecond |
| plugDetN | output | 1 | Low while a plug is reported |
| keyPress | output | 1 | High while the key is held |
| srcSelect | output | 1 | 0 = pull-up on sense pin, 1 = current source |
| biasClose | output | 1 | Close command for the mic bias switch |
| stateCode | output | 3 | Encoded current state |

## Verification
The state register is the only storage between the inputs and the outputs. So a flag change that needs no timing shows up on every output one clock edge after it is applied. A timed move shows up on the edge that samples the final qualifying tick. The bench changes inputs just after a falling edge and checks each output at the next falling edge, one rising edge later. It therefore reads every result in the cycle it becomes due. The tick-count sweeps run one tick short of each limit, then exactly to the limit. This shows that no move comes early and none comes late.

// File: rtl/jd_pkg.sv
package jd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SENSE   = 3'd1,
    ST_MOIST   = 3'd2,
    ST_PLUGGED = 3'd3,
    ST_ACTIVE  = 3'd4,
    ST_PRESSED = 3'd5,
    ST_RELEASE = 3'd6
  } jdState_t;

  localparam int NUM_LIMITS = 3;
  localparam int LIM_PLUG   = 0;
  localparam int LIM_BTN    = 1;
  localparam int LIM_REL    = 2;

  typedef struct packed {
    logic clr;
    logic inc;
  } tmrCtl_t;

endpackage

// File: rtl/jd_debounce_timer.sv
module jd_debounce_timer
  import jd_pkg::*;
#(
  parameter int PLUG_MS = 80,
  parameter int BTN_MS  = 30,
  parameter int REL_MS  = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tmrCtl_t               ctl,
  output logic [NUM_LIMITS-1:0] lastTick
);

  localparam int LIMS [NUM_LIMITS] = '{PLUG_MS, BTN_MS, REL_MS};
  localparam int MAX_A = (PLUG_MS > BTN_MS) ? PLUG_MS : BTN_MS;
  localparam int MAX_L = (MAX_A > REL_MS) ? MAX_A : REL_MS;
  localparam int CNT_W = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (ctl.clr) cnt <= '0;
    else if (ctl.inc) cnt <= cnt + 1'b1;
  end

  // one comparator per debounce length; the control picks the one it needs
  for (genvar g = 0; g < NUM_LIMITS; g++) begin : gLimit
    assign lastTick[g] = (cnt == CNT_W'(LIMS[g] - 1));
  end

  // R3 R7 R9: the shared count never runs past the longest window
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAX_L));

endmodule

// File: rtl/jd_control.sv
module jd_control
  import jd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wakeFlag,
  input  logic                  plugFlag,
  input  logic                  removeFlag,
  input  logic                  buttonFlag,
  input  logic                  hostEn,
  input  logic                  msTick,
  input  logic [NUM_LIMITS-1:0] lastTick,
  output tmrCtl_t               ctl,
  output logic                  plugDetN,
  output logic                  keyPress,
  output logic                  srcSelect,
  output logic                  biasClose,
  output logic [2:0]            stateCode
);

  jdState_t state, nextState;
  logic     qualify;
  logic     expire;

  // which flag level keeps the running window alive, and which limit ends it
  always_comb begin
    qualify = 1'b0;
    expire  = 1'b0;
    unique case (state)
      ST_SENSE: begin
        qualify = plugFlag && !removeFlag;
        expire  = lastTick[LIM_PLUG];
      end
      ST_ACTIVE: begin
        qualify = buttonFlag && hostEn && !removeFlag;
        expire  = lastTick[LIM_BTN];
      end
      ST_PRESSED: begin
        qualify = !buttonFlag && hostEn && !removeFlag;
        expire  = lastTick[LIM_BTN];
      end
      ST_RELEASE: begin
        qualify = 1'b1;
        expire  = lastTick[LIM_REL];
      end
      default: ;
    endcase
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (wakeFlag) nextState = ST_SENSE;
      ST_SENSE: begin
        if (removeFlag)                       nextState = ST_IDLE;
        else if (!plugFlag)                   nextState = ST_MOIST;
        else if (msTick && expire)            nextState = ST_PLUGGED;
      end
      ST_MOIST: begin
        if (removeFlag)     nextState = ST_IDLE;
        else if (plugFlag)  nextState = ST_SENSE;
      end
      ST_PLUGGED: begin
        if (removeFlag)     nextState = ST_RELEASE;
        else if (hostEn)    nextState = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (removeFlag)                       nextState = ST_RELEASE;
        else if (!hostEn)                     nextState = ST_PLUGGED;
        else if (qualify && msTick && expire) nextState = ST_PRESSED;
      end
      ST_PRESSED: begin
        if (removeFlag)                       nextState = ST_RELEASE;
        else if (!hostEn)                     nextState = ST_PLUGGED;
        else if (qualify && msTick && expire) nextState = ST_ACTIVE;
      end
      ST_RELEASE: if (msTick && expire) nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.clr = !qualify || (nextState != state);
    ctl.inc = qualify && msTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign plugDetN  = !(state inside {ST_PLUGGED, ST_ACTIVE, ST_PRESSED, ST_RELEASE});
  assign biasClose = (state == ST_ACTIVE) || (state == ST_PRESSED);
  assign keyPress  = (state == ST_PRESSED);
  assign srcSelect = (state != ST_IDLE);
  assign stateCode = state;

  // R2: a wake in idle selects the current source one edge later
  a_r2_wake_selects_source: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wakeFlag) |=> srcSelect);

  // R3: plug is reported only on a tick with the plug flag still present
  a_r3_plug_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(plugDetN) |-> ($past(msTick) && $past(plugFlag)));

  // R6: the bias path closes only while the host asked for it
  a_r6_bias_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    biasClose |-> $past(hostEn));

  // R10: key reported only with the bias path closed and a plug present
  a_r10_key_implies_bias: assert property (@(posedge clk) disable iff (!rstN)
    keyPress |-> (biasClose && !plugDetN));

  // R9: removal drops key and bias at once while plug-detect is held
  a_r9_removal_immediate: assert property (@(posedge clk) disable iff (!rstN)
    ((state inside {ST_PLUGGED, ST_ACTIVE, ST_PRESSED}) && removeFlag)
      |=> (!keyPress && !biasClose && !plugDetN));

  // R9: plug-detect rises only on a tick ending the hold
  a_r9_release_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(plugDetN) |-> $past(msTick));

endmodule

// File: rtl/jack_detect_ctrl.sv
module jack_detect_ctrl
  import jd_pkg::*;
#(
  parameter int PLUG_MS = 80,
  parameter int BTN_MS  = 30,
  parameter int REL_MS  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeFlag,
  input  logic       plugFlag,
  input  logic       removeFlag,
  input  logic       buttonFlag,
  input  logic       hostEn,
  input  logic       msTick,
  output logic       plugDetN,
  output logic       keyPress,
  output logic       srcSelect,
  output logic       biasClose,
  output logic [2:0] stateCode
);

  tmrCtl_t               tmrCtl;
  logic [NUM_LIMITS-1:0] lastTick;

  jd_debounce_timer #(
    .PLUG_MS(PLUG_MS),
    .BTN_MS (BTN_MS),
    .REL_MS (REL_MS)
  ) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (tmrCtl),
    .lastTick(lastTick)
  );

  jd_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wakeFlag  (wakeFlag),
    .plugFlag  (plugFlag),
    .removeFlag(removeFlag),
    .buttonFlag(buttonFlag),
    .hostEn    (hostEn),
    .msTick    (msTick),
    .lastTick  (lastTick),
    .ctl       (tmrCtl),
    .plugDetN  (plugDetN),
    .keyPress  (keyPress),
    .srcSelect (srcSelect),
    .biasClose (biasClose),
    .stateCode (stateCode)
  );

endmodule

// File: tb/tb_jack_detect_ctrl.sv
module tb_jack_detect_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int P_PLUG = 4;
  localparam int P_BTN  = 3;
  localparam int P_REL  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeFlag = 1'b0, plugFlag = 1'b0, removeFlag = 1'b0;
  logic buttonFlag = 1'b0, hostEn = 1'b0, msTick = 1'b0;
  logic plugDetN, keyPress, srcSelect, biasClose;
  logic [2:0] stateCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jack_detect_ctrl #(.PLUG_MS(P_PLUG), .BTN_MS(P_BTN), .REL_MS(P_REL)) dut (
    .clk(clk), .rstN(rstN), .wakeFlag(wakeFlag), .plugFlag(plugFlag),
    .removeFlag(removeFlag), .buttonFlag(buttonFlag), .hostEn(hostEn),
    .msTick(msTick), .plugDetN(plugDetN), .keyPress(keyPress),
    .srcSelect(srcSelect), .biasClose(biasClose), .stateCode(stateCode)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1;
      step();
      msTick = 1'b0;
    end
  endtask

  // expected outputs follow the per-code table of R10
  task automatic chk(input int expCode, input string req);
    logic [6:0] expV, gotV;
    expV = {3'(expCode),
            !(expCode >= 3 && expCode <= 6),
            (expCode == 5),
            (expCode != 0),
            (expCode == 4 || expCode == 5)};
    gotV = {stateCode, plugDetN, keyPress, srcSelect, biasClose};
    checks++;
    if (gotV !== expV) begin
      fails++;
      $display("FAIL %s: {code,detN,key,src,bias} got %b expected %b", req, gotV, expV);
    end
  endtask

  initial begin
    step();
    chk(0, "R1 in reset");
    step();
    rstN = 1'b1;
    step();
    chk(0, "R1 after reset");
    tick(2);
    chk(0, "R10 idle ignores ticks");

    // R2 wake
    wakeFlag = 1'b1; step(); wakeFlag = 1'b0;
    chk(1, "R2 wake enters sensing");

    // R5 removal in sensing
    removeFlag = 1'b1; step(); removeFlag = 1'b0;
    chk(0, "R5 removal in sensing");

    // R4 moisture path with restart
    wakeFlag = 1'b1; step(); wakeFlag = 1'b0;
    plugFlag = 1'b1;
    tick(P_PLUG - 1);
    chk(1, "R3 one tick short");
    plugFlag = 1'b0; step();
    chk(2, "R4 moisture entry");
    tick(1);
    chk(2, "R4 moisture holds");
    plugFlag = 1'b1; step();
    chk(1, "R4 back to sensing");
    // R3 sweep: plug reported exactly on the P_PLUG-th tick after restart
    for (int k = 1; k <= P_PLUG; k++) begin
      tick(1);
      chk((k == P_PLUG) ? 3 : 1, "R3 qualification sweep");
    end

    // R9 removal while plugged
    removeFlag = 1'b1; step(); removeFlag = 1'b0;
    chk(6, "R9 removal from plugged");
    tick(P_REL);
    chk(0, "R9 hold ends in idle");

    // R5 moisture to idle
    wakeFlag = 1'b1; step(); wakeFlag = 1'b0; plugFlag = 1'b0;
    step();
    chk(2, "R4 moisture direct");
    removeFlag = 1'b1; step(); removeFlag = 1'b0;
    chk(0, "R5 removal in moisture");

    // back to plugged, then active
    wakeFlag = 1'b1; step(); wakeFlag = 1'b0; plugFlag = 1'b1;
    tick(P_PLUG);
    chk(3, "R3 plugged again");
    tick(1);
    chk(3, "R6 no enable stays plugged");
    hostEn = 1'b1; step();
    chk(4, "R6 enable closes bias");

    // R7 sweep: runs shorter than P_BTN have no effect
    for (int n = 1; n < P_BTN; n++) begin
      buttonFlag = 1'b1;
      tick(n);
      buttonFlag = 1'b0;
      step();
      chk(4, "R7 short press ignored");
    end
    buttonFlag = 1'b1;
    tick(P_BTN);
    chk(5, "R7 full press");

    // R8 release with glitch restart
    buttonFlag = 1'b0;
    tick(P_BTN - 1);
    chk(5, "R8 short release held");
    buttonFlag = 1'b1; step(); buttonFlag = 1'b0;
    tick(P_BTN - 1);
    chk(5, "R8 release restarted");
    tick(1);
    chk(4, "R8 release complete");

    // R6 enable drop from pressed
    buttonFlag = 1'b1;
    tick(P_BTN);
    chk(5, "R7 press again");
    hostEn = 1'b0; step();
    chk(3, "R6 enable low leaves pressed");
    hostEn = 1'b1; step();
    chk(4, "R6 re-enable");
    tick(P_BTN);
    chk(5, "R7 press third");

    // R9 removal while pressed
    removeFlag = 1'b1; step(); removeFlag = 1'b0; buttonFlag = 1'b0;
    chk(6, "R9 removal from pressed");
    tick(P_REL - 1);
    chk(6, "R9 hold one tick short");
    tick(1);
    chk(0, "R9 hold expiry");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule